// File: doc/BRIEF.md
# Disk Controller Host Command and Status Port

This block is the host side of a controller that serves up to eight disk drives. The host issues a short function code on an output-control strobe. It then passes one or two 16-bit command words through a data port gated by a ready flag. It reads back a 16-bit status word through the same ready-gated port. It can also ask single-cycle yes/no questions ("skip tests") about the controller's condition.

The block decodes the first command word into write flag, unit, head, seek direction and cylinder offset. It checks seek targets against the cylinder count and keeps each unit's current cylinder and seeking flag. Drive mechanics and the data-moving engines sit outside. They are reached through a seek launch/landing pair and an operation start/done/abort handshake.

Interrupt handling is part of the block. Completions raise a request and an acknowledge function clears it. A seek that lands while the controller is busy with another command leaves a pending flag. That flag raises the request at the next completion.

The controller moves between four states:
- `ST_IDLE`: not busy.
- `ST_CW1`: waiting for command word 1.
- `ST_CW2`: waiting for the record address of a read/write.
- `ST_RUN`: an engine operation is in flight.

The transitions are:
- Start: `ST_IDLE`→`ST_CW1`.
- Word-1 launch or error: `ST_CW1`→`ST_IDLE`.
- Word-1 read/write: `ST_CW1`→`ST_CW2`.
- Word-1 engine operation: `ST_CW1`→`ST_RUN`.
- Word-2 accept: `ST_CW2`→`ST_RUN`.
- Completion: `ST_RUN`→`ST_IDLE`.
- Stop: any busy state→`ST_IDLE`.

Top module: `dskc_host_if`

## Requirements
- R1: After reset the block is not busy, ready is clear, the interrupt request and DMA select are low, all status flags are zero and no launch or start pulse is issued.
- R2: Function codes 0 (recalibrate), 1 (seek), 2 (read current address), 4 (unload), 5 (format) and 6 (read/write) start a command only when not busy. Starting sets busy and ready, clears every error flag and end-of-record, and enters `ST_CW1`. A start code received while busy has no effect.
- R3: A host write or read on the data port is accepted (`wr_acc`/`rd_acc`) only while ready is set. Each accepted access clears ready, and an accepted write stores the word in the data buffer.
- R4: Command word 1 holds the fields below. Read/write (code 6) sets ready again and waits in `ST_CW2` for a second word, the record address. Recalibrate, seek, read current address, unload and format need no second word. For read/write, read current address, unload and format, a one-cycle `op_go` carries the saved function, unit, head, write flag and record address.
  - bit 15: write
  - bits 13:11: unit
  - bits starting at 6: head
  - bit 8: seek direction (1 = toward lower cylinders)
  - bits 7:0: cylinder offset
- R5: A seek with offset zero, or whose target lies outside 0..NUM_CYL-1, ends the command with the seek-error flag set, clears busy and raises the interrupt. It does not launch a seek.
- R6: A valid seek or a recalibrate (target 0) clears busy when word 1 is accepted and pulses `seek_go` with unit and target cylinder. The unit then counts as seeking until `seek_done` names it. A landing while not busy raises the interrupt.
- R7: A landing while busy leaves the interrupt low and records a pending request. The request is raised at the next completion.
- R8: Word 1 naming a unit that is still seeking ends the command with the unsafe flag. Word 1 naming a unit whose `unit_present` bit is low ends it with the offline flag. Both raise the interrupt.
- R9: The status word has these bits:
  - 15: busy
  - 14: ready
  - 13: address error
  - 12: format error
  - 11: heads not loaded
  - 10: offline
  - 9: seek error
  - 5: write protect
  - 4: unsafe
  - 3: checksum
  - 2: rate error
  - 1: any error
  - 0: end of record
  - 8:6: always zero

  Read status (code 9) is ignored while busy. Otherwise it sets ready, recomputes any-error as the OR of bits 13, 12, 11, 10, 9, 5, 4 and 2 (not checksum), and latches the word into the data buffer.
- R10: The skip test `skt_hit` is true for these codes:
  - 0: ready
  - 1: interrupt low
  - 2: neither busy nor any error in the any-error set
  - 3: no such error
  - 4: not busy
  - 9+u: unit u (0..6) not seeking
  - 7: unit 7 not seeking
  - any other code: false
- R11: Engine completion (`op_done`) clears busy, merges `op_flags` into status and raises the interrupt, except that an unload raises it only when a request is pending. Acknowledge (code 12) clears the interrupt. A raise in the same cycle as an acknowledge wins.
- R12: Stop (code 8) returns to `ST_IDLE` and clears busy. If an engine operation was running, it pulses `op_abort` and raises the interrupt.
- R13: Code 11 sets `dma_sel` and code 15 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ocp_vld | input | 1 | Function strobe |
| ocp_fn | input | 4 | Function code |
| wr_vld | input | 1 | Host write request on data port |
| wr_data | input | 16 | Host write word |
| wr_acc | output | 1 | Host write accepted this cycle |
| rd_vld | input | 1 | Host read request on data port |
| rd_data | output | 16 | Data buffer contents |
| rd_acc | output | 1 | Host read accepted this cycle |
| skt_fn | input | 4 | Skip test code |
| skt_hit | output | 1 | Skip condition true |
| irq | output | 1 | Interrupt request |
| dma_sel | output | 1 | DMA transfer mode selected |
| unit_present | input | NUM_UNITS | Per-unit attached flag |
| seek_go | output | 1 | Seek launch pulse |
| seek_unit | output | UNIT_W | Unit being launched |
| seek_cyl | output | CYL_W | Target cylinder |
| seek_done | input | 1 | Seek landing pulse |
| seek_done_unit | input | UNIT_W | Unit that landed |
| op_go | output | 1 | Engine start pulse |
| op_fn | output | 4 | Function for the engine |
| op_unit | output | UNIT_W | Unit for the engine |
| op_head | output | HEAD_W | Head for the engine |
| op_wr | output | 1 | Write direction |
| op_addr | output | 16 | Record address (read/write) |
| op_abort | output | 1 | Engine abort pulse |
| op_done | input | 1 | Engine completion pulse |
| op_flags | input | 16 | Status flags reported at completion |

## Verification
Two functions can collide on the interrupt flag in one cycle. One case is a seek landing together with an acknowledge strobe. The bench first leaves the interrupt set by one landing. It then drives the acknowledge and a second unit's landing on the same edge, and judges the interrupt still high; only a later plain acknowledge drops it. The other case is a landing that arrives while an engine operation runs. There the interrupt must stay low and the not-seeking skip test must already flip. The request must appear only on the edge of `op_done`.

// File: rtl/dskc_pkg.sv
package dskc_pkg;

    localparam int WORD_W = 16;

    // function codes carried on the strobe
    localparam logic [3:0] FN_RECAL  = 4'd0;
    localparam logic [3:0] FN_SEEK   = 4'd1;
    localparam logic [3:0] FN_RDADDR = 4'd2;
    localparam logic [3:0] FN_UNLOAD = 4'd4;
    localparam logic [3:0] FN_FORMAT = 4'd5;
    localparam logic [3:0] FN_RDWR   = 4'd6;
    localparam logic [3:0] FN_STOP   = 4'd8;
    localparam logic [3:0] FN_STATUS = 4'd9;
    localparam logic [3:0] FN_DMA    = 4'd11;
    localparam logic [3:0] FN_ACK    = 4'd12;
    localparam logic [3:0] FN_IOBUS  = 4'd15;

    // status word bit positions
    localparam int SB_BUSY   = 15;
    localparam int SB_READY  = 14;
    localparam int SB_ADDR   = 13;
    localparam int SB_FMT    = 12;
    localparam int SB_HEADS  = 11;
    localparam int SB_OFFL   = 10;
    localparam int SB_SEEK   = 9;
    localparam int SB_WPROT  = 5;
    localparam int SB_UNSAFE = 4;
    localparam int SB_CSUM   = 3;
    localparam int SB_RATE   = 2;
    localparam int SB_ANY    = 1;
    localparam int SB_EOR    = 0;

    localparam logic [WORD_W-1:0] ERR_MASK  = 16'h3E34;
    localparam logic [WORD_W-1:0] MBZ_MASK  = 16'h01C0;
    localparam logic [WORD_W-1:0] START_CLR = ERR_MASK | 16'h000B;
    localparam logic [WORD_W-1:0] OP_MASK   = ~(MBZ_MASK | 16'h8002);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CW1,
        ST_CW2,
        ST_RUN
    } ctl_state_t;

    function automatic logic is_start_fn(input logic [3:0] fn);
        return (fn == FN_RECAL) || (fn == FN_SEEK) || (fn == FN_RDADDR) ||
               (fn == FN_UNLOAD) || (fn == FN_FORMAT) || (fn == FN_RDWR);
    endfunction

endpackage

// File: rtl/dskc_cw1_dec.sv
module dskc_cw1_dec #(
    parameter int UNIT_W  = 3,
    parameter int NUM_CYL = 203,
    parameter int CYL_W   = 8,
    parameter int HEAD_W  = 5,
    parameter logic [UNIT_W-1:0] UNIT_MASK = '1,
    parameter logic [HEAD_W-1:0] HEAD_MASK = '1
) (
    input  logic [15:0]                        cw1,
    input  logic [(1<<UNIT_W)*CYL_W-1:0]       cyl_flat,
    output logic [UNIT_W-1:0]                  unit,
    output logic [HEAD_W-1:0]                  head,
    output logic                               is_write,
    output logic [CYL_W-1:0]                   tgt,
    output logic                               tgt_bad
);
    localparam int SW = ((CYL_W > 8) ? CYL_W : 8) + 1;

    logic [7:0]    offs;
    logic          toward_low;
    logic [SW-1:0] cur_w, off_w, sum_w;

    assign unit       = cw1[11 +: UNIT_W] & UNIT_MASK;
    assign head       = cw1[6 +: HEAD_W] & HEAD_MASK;
    assign is_write   = cw1[15];
    assign toward_low = cw1[8];
    assign offs       = cw1[7:0];

    assign cur_w = SW'(cyl_flat[unit*CYL_W +: CYL_W]);
    assign off_w = SW'(offs);

    always_comb begin
        if (toward_low) begin
            sum_w   = cur_w - off_w;
            tgt_bad = (off_w > cur_w);
        end else begin
            sum_w   = cur_w + off_w;
            tgt_bad = (sum_w >= SW'(NUM_CYL));
        end
        if (offs == 8'd0) tgt_bad = 1'b1;
    end

    assign tgt = sum_w[CYL_W-1:0];
endmodule

// File: rtl/dskc_unit_track.sv
module dskc_unit_track #(
    parameter int CYL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CYL_W-1:0] tgt,
    input  logic             land,
    output logic             seeking,
    output logic [CYL_W-1:0] cyl
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seeking <= 1'b0;
            cyl     <= '0;
        end else if (launch) begin
            seeking <= 1'b1;
            cyl     <= tgt;
        end else if (land) begin
            seeking <= 1'b0;
        end
    end
endmodule

// File: rtl/dskc_skip.sv
module dskc_skip import dskc_pkg::*; #(
    parameter int UNIT_W = 3
) (
    input  logic [3:0]             fn,
    input  logic [WORD_W-1:0]      sta,
    input  logic                   irq,
    input  logic [(1<<UNIT_W)-1:0] seeking,
    output logic                   hit
);
    localparam int NUM_UNITS = 1 << UNIT_W;

    logic [7:0] still;
    logic       any_err;

    for (genvar i = 0; i < 8; i++) begin : g_still
        if (i < NUM_UNITS) begin : g_real
            assign still[i] = ~seeking[i];
        end else begin : g_pad
            assign still[i] = 1'b1;
        end
    end

    assign any_err = |(sta & ERR_MASK);

    always_comb begin
        case (fn)
            4'd0:    hit = sta[SB_READY];
            4'd1:    hit = ~irq;
            4'd2:    hit = ~(sta[SB_BUSY] | any_err);
            4'd3:    hit = ~any_err;
            4'd4:    hit = ~sta[SB_BUSY];
            4'd7:    hit = still[7];
            4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15:
                     hit = still[fn[2:0] - 3'd1];
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dskc_host_if.sv
module dskc_host_if import dskc_pkg::*; #(
    parameter int UNIT_W  = 3,
    parameter int NUM_CYL = 203,
    parameter int CYL_W   = 8,
    parameter int HEAD_W  = 5,
    parameter logic [UNIT_W-1:0] UNIT_MASK = '1,
    parameter logic [HEAD_W-1:0] HEAD_MASK = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ocp_vld,
    input  logic [3:0]               ocp_fn,
    input  logic                     wr_vld,
    input  logic [15:0]              wr_data,
    output logic                     wr_acc,
    input  logic                     rd_vld,
    output logic [15:0]              rd_data,
    output logic                     rd_acc,
    input  logic [3:0]               skt_fn,
    output logic                     skt_hit,
    output logic                     irq,
    output logic                     dma_sel,
    input  logic [(1<<UNIT_W)-1:0]   unit_present,
    output logic                     seek_go,
    output logic [UNIT_W-1:0]        seek_unit,
    output logic [CYL_W-1:0]         seek_cyl,
    input  logic                     seek_done,
    input  logic [UNIT_W-1:0]        seek_done_unit,
    output logic                     op_go,
    output logic [3:0]               op_fn,
    output logic [UNIT_W-1:0]        op_unit,
    output logic [HEAD_W-1:0]        op_head,
    output logic                     op_wr,
    output logic [15:0]              op_addr,
    output logic                     op_abort,
    input  logic                     op_done,
    input  logic [15:0]              op_flags
);
    localparam int NUM_UNITS = 1 << UNIT_W;

    ctl_state_t state, nstate;

    logic [WORD_W-1:0] sta_q, sta_d, stat_word, buf_q, buf_d, cw1_q, cw1_in;
    logic [3:0]        fn_q;
    logic              irq_q, defer_q, dma_q;
    logic              busy, ready;

    logic [NUM_UNITS-1:0]       unit_seeking;
    logic [NUM_UNITS*CYL_W-1:0] cyl_flat;

    logic [UNIT_W-1:0] dec_unit;
    logic [HEAD_W-1:0] dec_head;
    logic              dec_wr, dec_bad;
    logic [CYL_W-1:0]  dec_tgt, launch_cyl;

    logic start_ok, is_stop, status_ok, ack_now;
    logic ev_launch, ev_op, ev_fail, ev_cw2_wait, ev_opdone, ev_stop_run;
    logic complete_now, irq_raise;
    logic [WORD_W-1:0] fail_flags;

    assign busy      = (state != ST_IDLE);
    assign ready     = sta_q[SB_READY];
    assign wr_acc    = wr_vld & ready;
    assign rd_acc    = rd_vld & ready;
    assign start_ok  = ocp_vld && is_start_fn(ocp_fn) && !busy;
    assign is_stop   = ocp_vld && (ocp_fn == FN_STOP);
    assign status_ok = ocp_vld && (ocp_fn == FN_STATUS) && !busy;
    assign ack_now   = ocp_vld && (ocp_fn == FN_ACK);
    assign cw1_in    = (state == ST_CW1) ? wr_data : cw1_q;
    assign stat_word = {busy, sta_q[14:0]} & ~MBZ_MASK;

    dskc_cw1_dec #(
        .UNIT_W(UNIT_W), .NUM_CYL(NUM_CYL), .CYL_W(CYL_W), .HEAD_W(HEAD_W),
        .UNIT_MASK(UNIT_MASK), .HEAD_MASK(HEAD_MASK)
    ) i_dec (
        .cw1(cw1_in), .cyl_flat(cyl_flat), .unit(dec_unit), .head(dec_head),
        .is_write(dec_wr), .tgt(dec_tgt), .tgt_bad(dec_bad)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        dskc_unit_track #(.CYL_W(CYL_W)) i_track (
            .clk(clk), .rst_n(rst_n),
            .launch(ev_launch && (dec_unit == UNIT_W'(u))),
            .tgt(launch_cyl),
            .land(seek_done && (seek_done_unit == UNIT_W'(u))),
            .seeking(unit_seeking[u]),
            .cyl(cyl_flat[u*CYL_W +: CYL_W])
        );
    end

    dskc_skip #(.UNIT_W(UNIT_W)) i_skip (
        .fn(skt_fn), .sta(stat_word), .irq(irq_q),
        .seeking(unit_seeking), .hit(skt_hit)
    );

    // next-state and event decode
    always_comb begin
        nstate      = state;
        ev_launch   = 1'b0;
        ev_op       = 1'b0;
        ev_fail     = 1'b0;
        ev_cw2_wait = 1'b0;
        ev_opdone   = 1'b0;
        ev_stop_run = 1'b0;
        fail_flags  = '0;
        launch_cyl  = dec_tgt;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) nstate = ST_CW1;
            end
            ST_CW1: begin
                if (is_stop) begin
                    nstate = ST_IDLE;
                end else if (wr_acc) begin
                    if (unit_seeking[dec_unit]) begin
                        ev_fail = 1'b1;
                        fail_flags[SB_UNSAFE] = 1'b1;
                    end else if (!unit_present[dec_unit]) begin
                        ev_fail = 1'b1;
                        fail_flags[SB_OFFL] = 1'b1;
                    end else begin
                        case (fn_q)
                            FN_SEEK: begin
                                if (dec_bad) begin
                                    ev_fail = 1'b1;
                                    fail_flags[SB_SEEK] = 1'b1;
                                end else begin
                                    ev_launch = 1'b1;
                                end
                            end
                            FN_RECAL: begin
                                ev_launch  = 1'b1;
                                launch_cyl = '0;
                            end
                            FN_RDWR: ev_cw2_wait = 1'b1;
                            default: ev_op = 1'b1;
                        endcase
                    end
                    if (ev_fail || ev_launch) nstate = ST_IDLE;
                    else if (ev_cw2_wait)     nstate = ST_CW2;
                    else                      nstate = ST_RUN;
                end
            end
            ST_CW2: begin
                if (is_stop) begin
                    nstate = ST_IDLE;
                end else if (wr_acc) begin
                    ev_op  = 1'b1;
                    nstate = ST_RUN;
                end
            end
            ST_RUN: begin
                if (is_stop) begin
                    ev_stop_run = 1'b1;
                    nstate      = ST_IDLE;
                end else if (op_done) begin
                    ev_opdone = 1'b1;
                    nstate    = ST_IDLE;
                end
            end
        endcase
    end

    assign complete_now = ev_fail | ev_opdone | ev_stop_run;
    assign irq_raise    = ev_fail | ev_stop_run |
                          (ev_opdone && ((fn_q != FN_UNLOAD) || defer_q)) |
                          (seek_done && (!busy || complete_now));

    // status and data buffer next values
    always_comb begin
        sta_d = sta_q;
        buf_d = buf_q;
        if (rd_acc || wr_acc) sta_d[SB_READY] = 1'b0;
        if (wr_acc)           buf_d = wr_data;
        if (start_ok)         sta_d = (sta_d & ~START_CLR) | (16'h1 << SB_READY);
        if (ev_cw2_wait)      sta_d[SB_READY] = 1'b1;
        if (ev_fail)          sta_d = sta_d | fail_flags;
        if (ev_opdone)        sta_d = sta_d | (op_flags & OP_MASK);
        if (status_ok) begin
            sta_d[SB_READY] = 1'b1;
            sta_d[SB_ANY]   = |(sta_d & ERR_MASK);
        end
        sta_d[SB_BUSY] = 1'b0;
        sta_d          = sta_d & ~MBZ_MASK;
        if (status_ok) buf_d = sta_d;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q     <= '0;
            buf_q     <= '0;
            cw1_q     <= '0;
            fn_q      <= FN_RECAL;
            irq_q     <= 1'b0;
            defer_q   <= 1'b0;
            dma_q     <= 1'b0;
            seek_go   <= 1'b0;
            seek_unit <= '0;
            seek_cyl  <= '0;
            op_go     <= 1'b0;
            op_fn     <= '0;
            op_unit   <= '0;
            op_head   <= '0;
            op_wr     <= 1'b0;
            op_addr   <= '0;
            op_abort  <= 1'b0;
        end else begin
            sta_q    <= sta_d;
            buf_q    <= buf_d;
            if (state == ST_CW1 && wr_acc) cw1_q <= wr_data;
            if (start_ok) fn_q <= ocp_fn;
            if (irq_raise)    irq_q <= 1'b1;
            else if (ack_now) irq_q <= 1'b0;
            if (complete_now)           defer_q <= 1'b0;
            else if (seek_done && busy) defer_q <= 1'b1;
            if (ocp_vld && ocp_fn == FN_DMA)   dma_q <= 1'b1;
            if (ocp_vld && ocp_fn == FN_IOBUS) dma_q <= 1'b0;
            seek_go  <= ev_launch;
            if (ev_launch) begin
                seek_unit <= dec_unit;
                seek_cyl  <= launch_cyl;
            end
            op_go    <= ev_op;
            op_abort <= ev_stop_run;
            if (ev_op) begin
                op_fn   <= fn_q;
                op_unit <= dec_unit;
                op_head <= dec_head;
                op_wr   <= dec_wr;
                if (state == ST_CW2) op_addr <= wr_data;
            end
        end
    end

    assign rd_data = buf_q;
    assign irq     = irq_q;
    assign dma_sel = dma_q;
endmodule

// File: rtl/dskc_host_if_chk.sv
module dskc_host_if_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        ready,
    input logic        ocp_vld,
    input logic [3:0]  ocp_fn,
    input logic        rd_acc,
    input logic        wr_acc,
    input logic        op_done,
    input logic        seek_go,
    input logic        op_go,
    input logic [15:0] rd_data,
    input logic        irq,
    input logic        irq_raise
);
    // R3: an accepted read with nothing else touching ready leaves it clear
    p_read_clears_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc && !wr_acc && !ocp_vld && !op_done |=> !ready);

    // R2: a start code while running keeps the controller busy
    p_busy_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ocp_vld && ocp_fn == 4'd1 && !op_done |=> busy);

    // R6: a seek launch is only seen with busy already released
    p_seek_go_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seek_go |-> !busy);

    // R4: the engine start is a single-cycle pulse
    p_op_go_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |=> !op_go);

    // R9: read status when idle latches a word with zero bits 8:6 and sets ready
    p_status_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_vld && ocp_fn == 4'd9 && !busy |=> ready && rd_data[8:6] == 3'b000);

    // R11: acknowledge without a concurrent raise drops the request
    p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ocp_vld && ocp_fn == 4'd12 && !irq_raise |=> !irq);
endmodule

bind dskc_host_if dskc_host_if_chk i_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready),
    .ocp_vld(ocp_vld), .ocp_fn(ocp_fn), .rd_acc(rd_acc), .wr_acc(wr_acc),
    .op_done(op_done), .seek_go(seek_go), .op_go(op_go), .rd_data(rd_data),
    .irq(irq), .irq_raise(irq_raise)
);

// File: tb/test_dskc_host_if.sv
`timescale 1ns/1ps
module test_dskc_host_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ocp_vld = 1'b0;
    logic [3:0]  ocp_fn = '0;
    logic        wr_vld = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_acc;
    logic        rd_vld = 1'b0;
    logic [15:0] rd_data;
    logic        rd_acc;
    logic [3:0]  skt_fn = '0;
    logic        skt_hit;
    logic        irq, dma_sel;
    logic [7:0]  unit_present = 8'hDF;
    logic        seek_go;
    logic [2:0]  seek_unit;
    logic [7:0]  seek_cyl;
    logic        seek_done = 1'b0;
    logic [2:0]  seek_done_unit = '0;
    logic        op_go;
    logic [3:0]  op_fn;
    logic [2:0]  op_unit;
    logic [4:0]  op_head;
    logic        op_wr;
    logic [15:0] op_addr;
    logic        op_abort;
    logic        op_done = 1'b0;
    logic [15:0] op_flags = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dskc_host_if i_dskc_host_if (
        .clk(clk), .rst_n(rst_n), .ocp_vld(ocp_vld), .ocp_fn(ocp_fn),
        .wr_vld(wr_vld), .wr_data(wr_data), .wr_acc(wr_acc),
        .rd_vld(rd_vld), .rd_data(rd_data), .rd_acc(rd_acc),
        .skt_fn(skt_fn), .skt_hit(skt_hit), .irq(irq), .dma_sel(dma_sel),
        .unit_present(unit_present), .seek_go(seek_go), .seek_unit(seek_unit),
        .seek_cyl(seek_cyl), .seek_done(seek_done), .seek_done_unit(seek_done_unit),
        .op_go(op_go), .op_fn(op_fn), .op_unit(op_unit), .op_head(op_head),
        .op_wr(op_wr), .op_addr(op_addr), .op_abort(op_abort),
        .op_done(op_done), .op_flags(op_flags)
    );

    // seek table: {cw1, valid, expected target}; unit 0 starts at cylinder 0
    localparam logic [24:0] SEEK_VEC [7] = '{
        {16'h0000, 1'b0, 8'd0},
        {16'h000A, 1'b1, 8'd10},
        {16'h010B, 1'b0, 8'd0},
        {16'h00C0, 1'b1, 8'd202},
        {16'h0001, 1'b0, 8'd0},
        {16'h01CA, 1'b1, 8'd0},
        {16'h0104, 1'b0, 8'd0}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ocp(input logic [3:0] fn);
        ocp_vld = 1'b1; ocp_fn = fn;
        @(negedge clk);
        ocp_vld = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d, input logic exp_acc, input string tag);
        wr_vld = 1'b1; wr_data = d;
        #1 chk(wr_acc, exp_acc, tag);
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    task automatic rd(input logic [15:0] exp, input string tag);
        rd_vld = 1'b1;
        #1 chk(rd_acc, 1'b1, tag);
        chk(rd_data, exp, tag);
        @(negedge clk);
        rd_vld = 1'b0;
    endtask

    task automatic skp(input logic [3:0] fn, input logic exp, input string tag);
        skt_fn = fn;
        #1 chk(skt_hit, exp, tag);
    endtask

    task automatic land(input logic [2:0] u);
        seek_done = 1'b1; seek_done_unit = u;
        @(negedge clk);
        seek_done = 1'b0;
    endtask

    task automatic finish_op(input logic [15:0] flags);
        op_done = 1'b1; op_flags = flags;
        @(negedge clk);
        op_done = 1'b0; op_flags = '0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq, 1'b0, "R1 irq");
        chk(dma_sel, 1'b0, "R1 dma");
        chk(op_go, 1'b0, "R1 op_go");
        chk(seek_go, 1'b0, "R1 seek_go");
        skp(4'd4, 1'b1, "R1 not busy");
        skp(4'd0, 1'b0, "R1 ready low");
        skp(4'd3, 1'b1, "R1 no error");
        wr(16'h1234, 1'b0, "R3 write refused when not ready");

        // R5 R6 seek table
        for (int i = 0; i < 7; i++) begin
            logic [24:0] row;
            row = SEEK_VEC[i];
            ocp(4'd1);
            skp(4'd0, 1'b1, "R2 start sets ready");
            wr(row[24:9], 1'b1, "R3 cw1 accepted");
            if (row[8]) begin
                chk(seek_go, 1'b1, "R6 seek_go");
                chk(seek_cyl, row[7:0], "R6 seek_cyl");
                skp(4'd4, 1'b1, "R6 busy released");
                skp(4'd9, 1'b0, "R10 unit0 seeking");
                chk(irq, 1'b0, "R6 no irq before landing");
                land(3'd0);
                chk(irq, 1'b1, "R6 irq on landing");
                skp(4'd9, 1'b1, "R10 unit0 landed");
            end else begin
                chk(seek_go, 1'b0, "R5 no launch");
                chk(irq, 1'b1, "R5 irq");
                ocp(4'd9);
                rd(16'h4202, "R5 seek error status");
            end
            ocp(4'd12);
            chk(irq, 1'b0, "R11 ack");
        end

        // R4 read/write with second word
        ocp(4'd6);
        skp(4'd4, 1'b0, "R2 busy");
        wr(16'h90C0, 1'b1, "R4 cw1");
        skp(4'd0, 1'b1, "R4 ready for cw2");
        chk(op_go, 1'b0, "R4 no start before cw2");
        wr(16'hABCD, 1'b1, "R4 cw2");
        chk(op_go, 1'b1, "R4 op_go");
        chk(op_fn, 4'd6, "R4 op_fn");
        chk(op_unit, 3'd2, "R4 op_unit");
        chk(op_head, 5'd3, "R4 op_head");
        chk(op_wr, 1'b1, "R4 op_wr");
        chk(op_addr, 16'hABCD, "R4 op_addr");
        ocp(4'd1);
        chk(op_go, 1'b0, "R4 op_go pulse");
        skp(4'd0, 1'b0, "R2 start while busy ignored");
        finish_op(16'h0008);
        chk(irq, 1'b1, "R11 irq on completion");
        skp(4'd4, 1'b1, "R11 busy cleared");
        skp(4'd3, 1'b1, "R9 checksum not in error set");
        ocp(4'd9);
        rd(16'h4008, "R9 checksum status");
        ocp(4'd12);

        // R8 offline unit 5
        ocp(4'd2);
        wr(16'h2800, 1'b1, "R8 cw1");
        chk(irq, 1'b1, "R8 offline irq");
        skp(4'd2, 1'b0, "R10 not operational");
        skp(4'd3, 1'b0, "R10 error present");
        ocp(4'd9);
        rd(16'h4402, "R8 offline status");
        ocp(4'd12);

        // R8 unsafe: unit 1 still seeking
        ocp(4'd1);
        wr(16'h0805, 1'b1, "R6 seek unit1");
        chk(seek_unit, 3'd1, "R6 seek_unit");
        chk(seek_cyl, 8'd5, "R6 seek_cyl unit1");
        skp(4'd10, 1'b0, "R10 unit1 seeking");
        ocp(4'd2);
        wr(16'h0800, 1'b1, "R8 cw1 to seeking unit");
        chk(irq, 1'b1, "R8 unsafe irq");
        ocp(4'd9);
        rd(16'h4012, "R8 unsafe status");
        ocp(4'd12);

        // R7 landing while busy is deferred
        ocp(4'd2);
        wr(16'h1800, 1'b1, "R7 cw1 unit3");
        chk(op_go, 1'b1, "R4 read address starts at once");
        land(3'd1);
        chk(irq, 1'b0, "R7 deferred");
        skp(4'd10, 1'b1, "R10 unit1 landed");
        ocp(4'd9);
        rd_vld = 1'b1;
        #1 chk(rd_acc, 1'b0, "R9 status while busy ignored");
        @(negedge clk);
        rd_vld = 1'b0;
        finish_op(16'h0000);
        chk(irq, 1'b1, "R7 raised at completion");
        ocp(4'd12);

        // R11 unload completes without interrupt; R9 bits 8:6 stay zero
        ocp(4'd4);
        wr(16'h1800, 1'b1, "R4 unload cw1");
        chk(op_fn, 4'd4, "R4 unload op_fn");
        finish_op(16'h01C1);
        chk(irq, 1'b0, "R11 unload no irq");
        skp(4'd4, 1'b1, "R11 unload busy cleared");
        ocp(4'd9);
        rd(16'h4001, "R9 mbz bits");

        // R12 stop while running
        ocp(4'd5);
        wr(16'h1800, 1'b1, "R12 format cw1");
        ocp(4'd8);
        chk(op_abort, 1'b1, "R12 abort");
        chk(irq, 1'b1, "R12 irq");
        skp(4'd4, 1'b1, "R12 busy cleared");
        ocp(4'd12);

        // R11 acknowledge and landing in the same cycle
        ocp(4'd1);
        wr(16'h3001, 1'b1, "R6 seek unit6");
        ocp(4'd1);
        wr(16'h2003, 1'b1, "R6 seek unit4");
        land(3'd6);
        chk(irq, 1'b1, "R6 unit6 irq");
        ocp_vld = 1'b1; ocp_fn = 4'd12;
        seek_done = 1'b1; seek_done_unit = 3'd4;
        @(negedge clk);
        ocp_vld = 1'b0; seek_done = 1'b0;
        chk(irq, 1'b1, "R11 raise beats ack");
        ocp(4'd12);
        chk(irq, 1'b0, "R11 plain ack");

        // R13 transfer mode
        ocp(4'd11);
        chk(dma_sel, 1'b1, "R13 dma on");
        ocp(4'd15);
        chk(dma_sel, 1'b0, "R13 dma off");

        summary();
    end
endmodule